// File: doc/BRIEF.md
# Power-up SRAM Parameter Loader

This block sits between an external controller and one single-port synchronous SRAM whose controls are active low. While the external side keeps its ready flag low, the block is transparent: the SRAM enable, write strobe, address and write data are simply the controller's own signals, so the controller can fill the memory with whatever it needs.

When the ready flag goes high, the block takes over the SRAM. It keeps the memory enabled in read mode and walks the lowest five addresses in ascending order. Each word arrives one clock after its address, and the block places it in its own parameter register. A step counter paces the walk. When the counter reaches six, the block disables the SRAM and pulses a done flag for one cycle. After that it leaves the memory disabled until the ready flag falls. A later rise of the flag runs a fresh load.

Top module: `sram_param_loader`

## Requirements
- R1: While init_ready is 0, sram_cen_n, sram_wen_n, sram_addr and sram_wdata equal ext_cen_n, ext_wen_n, ext_addr and ext_wdata in the same cycle (combinational path).
- R2: During a load, with init_ready at 1, the outputs are driven as follows: sram_cen_n is 0 and sram_wen_n is 1, so the SRAM reads. sram_ema is 0 and sram_retn is 1.
- R3: A load starts at the first rising edge that samples init_ready high while the block is armed. In the five cycles that follow that edge, sram_addr is 0, 1, 2, 3 and 4, in that order.
- R4: The SRAM returns the word for an address one cycle after that address is presented. The word read from address k is held in param_words[8k+7:8k], for k = 0 to 4. It is valid from the cycle in which load_done is 1.
- R5: Once a load has completed and while init_ready stays 1, sram_cen_n is 1 and no further read happens.
- R6: load_done is 1 for exactly one cycle, the seventh cycle after the starting edge (step count 6). It is 0 at all other times.
- R7: After a synchronous active-high reset, the outputs and state are as follows: every parameter register is 0, load_done is 0 and the block is armed.
- R8: If init_ready falls during a load, the load is abandoned and the bypass of R1 resumes. The next rise of init_ready restarts the load from address 0.
- R9: While init_ready is held at 1 after a completed load, the block neither starts another load nor pulses load_done, and param_words keeps its values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| init_ready | input | 1 | External side has finished filling the SRAM |
| ext_cen_n | input | 1 | Controller chip enable, active low |
| ext_wen_n | input | 1 | Controller write enable, active low |
| ext_addr | input | 8 | Controller address |
| ext_wdata | input | 8 | Controller write data |
| sram_rdata | input | 8 | SRAM read data, one cycle after the address |
| sram_cen_n | output | 1 | SRAM chip enable, active low |
| sram_wen_n | output | 1 | SRAM write enable, active low |
| sram_addr | output | 8 | SRAM address |
| sram_wdata | output | 8 | SRAM write data |
| sram_ema | output | 3 | SRAM margin control, held at 0 |
| sram_retn | output | 1 | SRAM retention control, held at 1 |
| param_words | output | 40 | Five captured parameter words, word k at bits 8k+7:8k |
| load_done | output | 1 | One-cycle pulse when loading completes |

## Verification
The assertions check several properties on every cycle:
- the read-mode drive whenever the block owns the memory;
- the one-cycle width of the done pulse;
- the release of the enable at completion;
- the advance of the step counter by one per cycle;
- the abandonment of a load when the ready flag falls.

Some behaviour only the bench's scenarios can show, because it depends on data or ordering that the SRAM model carries:
- that each parameter register holds the word from its own address, given the read latency;
- that the address order is 0 to 4;
- that a restart after an abort begins again at address 0;
- that holding the flag high after completion leaves the parameters untouched.

// File: rtl/sram_param_loader_pkg.sv
package sram_param_loader_pkg;

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_LOAD   = 2'd1,
        ST_FINISH = 2'd2,
        ST_HOLD   = 2'd3
    } ld_state_e;

endpackage

// File: rtl/spl_sequencer.sv
module spl_sequencer
    import sram_param_loader_pkg::*;
#(
    parameter int NUM_PARAMS = 5,
    parameter int ADDR_W     = 8,
    parameter int STEP_W     = $clog2(NUM_PARAMS + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_ready,
    output logic              own_active,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cap_en,
    output logic [STEP_W-1:0] cap_idx,
    output logic              done_o
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_PARAMS);
    localparam logic [STEP_W-1:0] LAST_ADDR = STEP_W'(NUM_PARAMS - 1);

    typedef struct packed {
        ld_state_e         state;
        logic [STEP_W-1:0] step;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            ST_ARMED: begin
                if (init_ready) begin
                    seq_d.state = ST_LOAD;
                    seq_d.step  = '0;
                end
            end
            ST_LOAD: begin
                if (!init_ready) begin
                    seq_d.state = ST_ARMED;
                    seq_d.step  = '0;
                end else begin
                    seq_d.step = seq_q.step + 1'b1;
                    if (seq_q.step == LAST_STEP) begin
                        seq_d.state = ST_FINISH;
                    end
                end
            end
            ST_FINISH: begin
                seq_d.state = init_ready ? ST_HOLD : ST_ARMED;
                seq_d.step  = '0;
            end
            default: begin
                if (!init_ready) begin
                    seq_d.state = ST_ARMED;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.state <= ST_ARMED;
            seq_q.step  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign own_active = (seq_q.state == ST_LOAD);
    assign rd_addr    = (seq_q.step < LAST_STEP) ? ADDR_W'(seq_q.step) : ADDR_W'(LAST_ADDR);
    assign cap_en     = own_active && init_ready && (seq_q.step != '0);
    assign cap_idx    = seq_q.step - 1'b1;
    assign done_o     = (seq_q.state == ST_FINISH);

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (own_active && init_ready) |=> (seq_q.step == $past(seq_q.step) + 1'b1)); // R3

    AST_ABORT_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        (own_active && !init_ready) |=> !own_active); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R6

endmodule

// File: rtl/spl_capture_bank.sv
module spl_capture_bank #(
    parameter int NUM_PARAMS = 5,
    parameter int DATA_W     = 8,
    parameter int STEP_W     = $clog2(NUM_PARAMS + 2)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cap_en,
    input  logic [STEP_W-1:0]            cap_idx,
    input  logic [DATA_W-1:0]            rdata,
    output logic [NUM_PARAMS*DATA_W-1:0] words
);
    logic [DATA_W-1:0] word_d [NUM_PARAMS];
    logic [DATA_W-1:0] word_q [NUM_PARAMS];

    always_comb begin
        for (int i = 0; i < NUM_PARAMS; i++) begin
            word_d[i] = (cap_en && (cap_idx == STEP_W'(i))) ? rdata : word_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_PARAMS; i++) begin
            if (rst) begin
                word_q[i] <= '0;
            end else begin
                word_q[i] <= word_d[i];
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_PARAMS; g++) begin : g_out
            assign words[g*DATA_W +: DATA_W] = word_q[g];
        end
    endgenerate

    AST_CAPTURE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cap_en |-> (cap_idx < STEP_W'(NUM_PARAMS))); // R4

endmodule

// File: rtl/spl_port_mux.sv
module spl_port_mux #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int EMA_W  = 3
) (
    input  logic              init_ready,
    input  logic              own_active,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ext_cen_n,
    input  logic              ext_wen_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [DATA_W-1:0] ext_wdata,
    output logic              sram_cen_n,
    output logic              sram_wen_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    output logic [EMA_W-1:0]  sram_ema,
    output logic              sram_retn
);
    always_comb begin
        sram_ema  = '0;
        sram_retn = 1'b1;
        if (!init_ready) begin
            sram_cen_n = ext_cen_n;
            sram_wen_n = ext_wen_n;
            sram_addr  = ext_addr;
            sram_wdata = ext_wdata;
        end else if (own_active) begin
            sram_cen_n = 1'b0;
            sram_wen_n = 1'b1;
            sram_addr  = own_addr;
            sram_wdata = '0;
        end else begin
            sram_cen_n = 1'b1;
            sram_wen_n = 1'b1;
            sram_addr  = '0;
            sram_wdata = '0;
        end
    end

endmodule

// File: rtl/sram_param_loader.sv
module sram_param_loader #(
    parameter int NUM_PARAMS = 5,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int EMA_W      = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         init_ready,
    input  logic                         ext_cen_n,
    input  logic                         ext_wen_n,
    input  logic [ADDR_W-1:0]            ext_addr,
    input  logic [DATA_W-1:0]            ext_wdata,
    input  logic [DATA_W-1:0]            sram_rdata,
    output logic                         sram_cen_n,
    output logic                         sram_wen_n,
    output logic [ADDR_W-1:0]            sram_addr,
    output logic [DATA_W-1:0]            sram_wdata,
    output logic [EMA_W-1:0]             sram_ema,
    output logic                         sram_retn,
    output logic [NUM_PARAMS*DATA_W-1:0] param_words,
    output logic                         load_done
);
    localparam int STEP_W = $clog2(NUM_PARAMS + 2);

    logic              own_active;
    logic [ADDR_W-1:0] own_addr;
    logic              cap_en;
    logic [STEP_W-1:0] cap_idx;

    spl_sequencer #(
        .NUM_PARAMS (NUM_PARAMS),
        .ADDR_W     (ADDR_W),
        .STEP_W     (STEP_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .init_ready (init_ready),
        .own_active (own_active),
        .rd_addr    (own_addr),
        .cap_en     (cap_en),
        .cap_idx    (cap_idx),
        .done_o     (load_done)
    );

    spl_capture_bank #(
        .NUM_PARAMS (NUM_PARAMS),
        .DATA_W     (DATA_W),
        .STEP_W     (STEP_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .cap_idx (cap_idx),
        .rdata   (sram_rdata),
        .words   (param_words)
    );

    spl_port_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .EMA_W  (EMA_W)
    ) u_mux (
        .init_ready (init_ready),
        .own_active (own_active),
        .own_addr   (own_addr),
        .ext_cen_n  (ext_cen_n),
        .ext_wen_n  (ext_wen_n),
        .ext_addr   (ext_addr),
        .ext_wdata  (ext_wdata),
        .sram_cen_n (sram_cen_n),
        .sram_wen_n (sram_wen_n),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_ema   (sram_ema),
        .sram_retn  (sram_retn)
    );

    AST_READ_MODE_OWNED: assert property (@(posedge clk) disable iff (rst)
        (own_active && init_ready) |-> (!sram_cen_n && sram_wen_n && sram_ema == '0 && sram_retn)); // R2

    AST_RELEASE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        load_done |-> sram_cen_n); // R5

    AST_NO_CAPTURE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (load_done && init_ready) |=> $stable(param_words)); // R9

endmodule

// File: tb/sram_param_loader_bench.sv
`timescale 1ns/1ps
module sram_param_loader_bench;
    localparam int NP = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic       init_ready;
    logic       ext_cen_n, ext_wen_n;
    logic [7:0] ext_addr, ext_wdata;
    logic [7:0] sram_rdata;
    logic       sram_cen_n, sram_wen_n;
    logic [7:0] sram_addr, sram_wdata;
    logic [2:0] sram_ema;
    logic       sram_retn;
    logic [NP*8-1:0] param_words;
    logic       load_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0] mem     [256];
    logic [7:0] exp_mem [256];

    always #2 clk = ~clk;

    sram_param_loader u_sram_param_loader (
        .clk(clk), .rst(rst), .init_ready(init_ready),
        .ext_cen_n(ext_cen_n), .ext_wen_n(ext_wen_n),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .sram_rdata(sram_rdata),
        .sram_cen_n(sram_cen_n), .sram_wen_n(sram_wen_n),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .sram_ema(sram_ema), .sram_retn(sram_retn),
        .param_words(param_words), .load_done(load_done)
    );

    // single-port SRAM model, one-cycle read latency
    always @(posedge clk) begin
        if (!sram_cen_n) begin
            if (!sram_wen_n) mem[sram_addr] <= sram_wdata;
            else             sram_rdata <= mem[sram_addr];
        end
    end

    function automatic logic [7:0] exp_param(int k);
        return exp_mem[k];
    endfunction

    function automatic logic [7:0] got_param(int k);
        return param_words[k*8 +: 8];
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_bypass(string req);
        #1;
        chk(sram_cen_n == ext_cen_n, req, sram_cen_n, ext_cen_n);
        chk(sram_wen_n == ext_wen_n, req, sram_wen_n, ext_wen_n);
        chk(sram_addr == ext_addr, req, sram_addr, ext_addr);
        chk(sram_wdata == ext_wdata, req, sram_wdata, ext_wdata);
    endtask

    task automatic write_word(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        ext_cen_n = 1'b0; ext_wen_n = 1'b0; ext_addr = a; ext_wdata = d;
        exp_mem[a] = d;
        check_bypass("R1");
        @(negedge clk);
        ext_cen_n = 1'b1; ext_wen_n = 1'b1;
    endtask

    task automatic fill_params(bit directed, logic [7:0] pat);
        for (int k = 0; k < NP; k++) begin
            logic [7:0] d;
            d = directed ? (((k % 2) == 0) ? pat : ~pat) : 8'($urandom);
            write_word(8'(k), d);
        end
    endtask

    task automatic run_load();
        @(negedge clk);
        ext_cen_n = 1'b1; ext_wen_n = 1'b1;
        init_ready = 1'b1;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (i < 5) begin
                chk(sram_addr == 8'(i), "R3", sram_addr, i);
                chk(!sram_cen_n && sram_wen_n && sram_ema == 3'd0 && sram_retn, "R2",
                    {sram_cen_n, sram_wen_n}, 2'b01);
            end
            if (i < 6) chk(load_done == 1'b0, "R6", load_done, 0);
            else begin
                chk(load_done == 1'b1, "R6", load_done, 1);
                chk(sram_cen_n == 1'b1, "R5", sram_cen_n, 1);
                for (int k = 0; k < NP; k++)
                    chk(got_param(k) == exp_param(k), "R4", got_param(k), exp_param(k));
            end
        end
        @(negedge clk);
        chk(load_done == 1'b0, "R6", load_done, 0);
    endtask

    task automatic hold_high(int n);
        logic [NP*8-1:0] snap;
        snap = param_words;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(load_done == 1'b0, "R9", load_done, 0);
            chk(sram_cen_n == 1'b1, "R5", sram_cen_n, 1);
        end
        chk(param_words == snap, "R9", 0, 0);
    endtask

    task automatic drop_ready();
        @(negedge clk);
        init_ready = 1'b0;
        check_bypass("R1");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'h00; exp_mem[i] = 8'h00;
        end
        rst = 1'b1; init_ready = 1'b0;
        ext_cen_n = 1'b1; ext_wen_n = 1'b1; ext_addr = '0; ext_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(load_done == 1'b0, "R7", load_done, 0);
        chk(param_words == '0, "R7", 0, 0);

        // random bypass traffic
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            ext_cen_n = 1'($urandom); ext_wen_n = 1'($urandom);
            ext_addr = 8'($urandom); ext_wdata = 8'($urandom);
            if (!ext_cen_n && !ext_wen_n) exp_mem[ext_addr] = ext_wdata;
            check_bypass("R1");
        end
        @(negedge clk);
        ext_cen_n = 1'b1; ext_wen_n = 1'b1;

        fill_params(0, 8'h00);
        run_load();
        hold_high(10);
        drop_ready();

        // directed data corners
        fill_params(1, 8'hFF);
        run_load();
        drop_ready();
        fill_params(1, 8'hA5);
        run_load();
        drop_ready();

        // abort mid-load, then restart
        fill_params(0, 8'h00);
        @(negedge clk);
        init_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk(sram_addr == 8'd2, "R3", sram_addr, 2);
        init_ready = 1'b0;
        ext_cen_n = 1'b1; ext_wen_n = 1'b1; ext_addr = 8'h33; ext_wdata = 8'h44;
        check_bypass("R8");
        repeat (2) @(negedge clk);
        chk(load_done == 1'b0, "R8", load_done, 0);
        fill_params(0, 8'h00);
        run_load();
        drop_ready();

        // random rounds
        for (int r = 0; r < 4; r++) begin
            fill_params(0, 8'h00);
            run_load();
            hold_high(int'($urandom_range(1, 6)));
            drop_ready();
        end

        finish_run();
    end

endmodule